// File: doc/BRIEF.md
# Basic-Mode 24-Line Parallel Port Group

This block is a register-mapped group of 24 general-purpose digital lines, split into three 8-bit ports (A, B and C) plus one control register, all reached over a byte-wide host bus. The bus has a 2-bit address, a read strobe and a write strobe. The block supports only the simple basic I/O mode. There are no handshaken, strobed or bidirectional modes, and there is no per-bit command for port C.

Each line has three parts. An output latch holds the value the host wrote. An output enable decides whether that latch drives the pad. A two-stage synchronizer samples the pad level for reads. Direction is set by one packed mode word. Ports A and B change direction as whole bytes. Port C changes direction as two independent 4-bit halves. A host normally starts up by writing a mode word that makes every port an output, then writing zero to the three port registers.

Top module: `ppg_group`

## Requirements
- R1: While reset is active, and in the first cycle after it, every `pin_oe` bit is 0 (all lines are inputs) and every `pin_out` bit is 0.
- R2: A write to offset 3 with bit 7 set is a mode word, and it takes effect at that clock edge. In the mode word, bit 4 sets the direction of port A (`pin_*[7:0]`) and bit 1 sets port B (`pin_*[15:8]`). A direction bit of 1 means input, and `pin_oe` for those lines is then 0. A bit of 0 sets `pin_oe` to 1.
- R3: In the mode word, bit 3 sets the direction of the upper half of port C (`pin_*[23:20]`) and bit 0 sets the lower half (`pin_*[19:16]`). Each half follows only its own bit.
- R4: A write to offset 0, 1 or 2 loads the port A, B or C output latch respectively. The new value appears on `pin_out` after that edge, and the other two latches keep their values.
- R5: A port write loads the latch whatever the direction of the port. The `pin_oe` bits are not changed by any port write.
- R6: A read at offset 0, 1 or 2 returns, on `bus_rdata` in the same cycle, the level of that port's pins as sampled two clock edges earlier. A level applied before edge k can be read after edge k+1, and not after edge k.
- R7: Every mode word clears all three output latches to 0 at the same edge that sets the new directions.
- R8: A write to offset 3 with bit 7 clear changes neither `pin_oe` nor `pin_out`.
- R9: A read of offset 3 returns 0. When `bus_rd` is low, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register offset: 0 port A, 1 port B, 2 port C, 3 control |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_rdata | output | 8 | Read data |
| pin_in | input | 24 | Pad input levels, asynchronous |
| pin_out | output | 24 | Output latch values toward the pads |
| pin_oe | output | 24 | Pad output enables, 1 = drive |

## Verification
The bench walks through every single-group direction change, one at a time. A design that swapped the port A and port B bits, or that tied the two halves of port C together, would enable the wrong 8 or 4 lines. It checks that a mode word wipes latches that were loaded earlier, and that a control write with bit 7 clear leaves both pins and latches alone. A design that decoded control writes without the flag bit would drop the latched data. The exact read latency is checked by reading one cycle too early and then exactly on time: a design with one synchronizer stage, or with three, would return the new value early or the old value late. A mid-run reset is also applied, to show that the enables and latches go back to their safe state.

// File: rtl/ppg_pkg.sv
// Package: shared constants for the basic-mode parallel port group.
// Assumes a byte-wide control word; the bit positions below are decoded
// by the mode register and must match the host's mode-word layout.
package ppg_pkg;
    localparam int NUM_PORTS = 3;
    localparam int ADDR_W    = 2;

    // Register offsets within a group
    localparam logic [ADDR_W-1:0] OFS_PA   = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_PB   = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_PC   = 2'd2;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 2'd3;

    // Mode-word bit positions (1 = input)
    localparam int BIT_MODE_FLAG = 7;
    localparam int BIT_DIR_A     = 4;
    localparam int BIT_DIR_CHI   = 3;
    localparam int BIT_DIR_B     = 1;
    localparam int BIT_DIR_CLO   = 0;

    // Direction state held by the mode register; 1 = input
    typedef struct packed {
        logic a_in;
        logic b_in;
        logic chi_in;
        logic clo_in;
    } ppg_dir_t;

    localparam ppg_dir_t DIR_ALL_IN = '{a_in: 1'b1, b_in: 1'b1, chi_in: 1'b1, clo_in: 1'b1};
endpackage

// File: rtl/ppg_mode_reg.sv
// Mode register: decodes control writes and holds the four direction bits.
// Assumes the caller qualifies wr_ctrl with the control offset. A write with
// the flag bit clear is dropped. clr_latch pulses combinationally on every
// accepted mode word so the port latches clear at the same edge.
module ppg_mode_reg
    import ppg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output ppg_dir_t          dir,
    output logic              clr_latch
);
    logic mode_hit;

    // Accept only control writes that carry the mode flag
    always_comb begin
        mode_hit  = wr_ctrl && wdata[BIT_MODE_FLAG];
        clr_latch = mode_hit;
    end

    // Hold the direction bits; reset leaves every group as input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir <= DIR_ALL_IN;
        end else if (mode_hit) begin
            dir.a_in   <= wdata[BIT_DIR_A];
            dir.b_in   <= wdata[BIT_DIR_B];
            dir.chi_in <= wdata[BIT_DIR_CHI];
            dir.clo_in <= wdata[BIT_DIR_CLO];
        end
    end
endmodule

// File: rtl/ppg_out_latch.sv
// Output latch for one port. A clear takes priority over a load; the two
// cannot coincide from a single bus write, but the order is fixed anyway.
// Assumes synchronous active-low reset to zero.
module ppg_out_latch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clr,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    // Store host data, cleared by reset or by a mode word
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end
endmodule

// File: rtl/ppg_in_sync.sv
// Two-stage synchronizer for asynchronous pad inputs. The stages are
// deliberately not reset: they only carry pad levels and settle within
// two clocks of any reset, which keeps reset off the metastability path.
module ppg_in_sync #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage1;

    // Shift pad levels through two flops
    always_ff @(posedge clk) begin
        stage1 <= d_async;
        q_sync <= stage1;
    end
endmodule

// File: rtl/ppg_group.sv
// Basic-mode 24-line parallel port group. It decodes the byte bus into
// three port latches and a mode register, expands the direction bits into
// per-line output enables (byte-wide for ports A and B, nibble-wide for C),
// and returns synchronized pad levels on reads. Assumes one bus access per
// cycle and that the pads tri-state themselves from pin_oe.
module ppg_group
    import ppg_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [PORT_W-1:0]             bus_wdata,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    output logic [PORT_W-1:0]             bus_rdata,
    input  logic [NUM_PORTS*PORT_W-1:0]   pin_in,
    output logic [NUM_PORTS*PORT_W-1:0]   pin_out,
    output logic [NUM_PORTS*PORT_W-1:0]   pin_oe
);
    localparam int LINES  = NUM_PORTS * PORT_W;
    localparam int HALF_W = PORT_W / 2;

    ppg_dir_t          dir;
    logic              clr_latch;
    logic              wr_ctrl;
    logic [LINES-1:0]  pin_sync;
    logic [NUM_PORTS-1:0] port_load;

    // Qualify a write to the control offset
    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    end

    ppg_mode_reg #(.DATA_W(PORT_W)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wdata     (bus_wdata),
        .dir       (dir),
        .clr_latch (clr_latch)
    );

    ppg_in_sync #(.WIDTH(LINES)) u_sync (
        .clk     (clk),
        .d_async (pin_in),
        .q_sync  (pin_sync)
    );

    // One latch per port, selected by its offset
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        always_comb begin
            port_load[p] = bus_wr && (bus_addr == ADDR_W'(p));
        end

        ppg_out_latch #(.WIDTH(PORT_W)) u_latch (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (port_load[p]),
            .clr   (clr_latch),
            .din   (bus_wdata),
            .q     (pin_out[p*PORT_W +: PORT_W])
        );
    end

    // Expand direction bits into per-line enables: drive when not input
    always_comb begin
        pin_oe[0*PORT_W +: PORT_W]          = {PORT_W{~dir.a_in}};
        pin_oe[1*PORT_W +: PORT_W]          = {PORT_W{~dir.b_in}};
        pin_oe[2*PORT_W +: HALF_W]          = {HALF_W{~dir.clo_in}};
        pin_oe[2*PORT_W + HALF_W +: HALF_W] = {HALF_W{~dir.chi_in}};
    end

    // Return synchronized pad levels for a port read, zero otherwise
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                OFS_PA:   bus_rdata = pin_sync[0*PORT_W +: PORT_W];
                OFS_PB:   bus_rdata = pin_sync[1*PORT_W +: PORT_W];
                OFS_PC:   bus_rdata = pin_sync[2*PORT_W +: PORT_W];
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ppg_group_chk.sv
// Checker for ppg_group: temporal properties on the block's ports, bound
// to every instance of the top module.
module ppg_group_chk
    import ppg_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [PORT_W-1:0]           bus_wdata,
    input logic                        bus_wr,
    input logic                        bus_rd,
    input logic [PORT_W-1:0]           bus_rdata,
    input logic [NUM_PORTS*PORT_W-1:0] pin_in,
    input logic [NUM_PORTS*PORT_W-1:0] pin_out,
    input logic [NUM_PORTS*PORT_W-1:0] pin_oe
);
    logic mode_wr;
    assign mode_wr = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[BIT_MODE_FLAG];

    // R1: first cycle out of reset is safe
    p_reset_safe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pin_oe == '0) && (pin_out == '0));

    // R2: enables move only on a mode word
    p_oe_only_on_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> $stable(pin_oe));

    // R4: port A write lands on its pins
    p_port_a_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_PA) |=> pin_out[PORT_W-1:0] == $past(bus_wdata));

    // R6: read returns pins from two edges back
    p_read_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_PC) |-> bus_rdata == $past(pin_in[2*PORT_W +: PORT_W], 2));

    // R7: mode word clears every latch
    p_mode_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> pin_out == '0);

    // R8: control write without flag is inert
    p_ctrl_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CTRL && !bus_wdata[BIT_MODE_FLAG])
        |=> $stable(pin_oe) && $stable(pin_out));

    // R9: idle bus reads as zero
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == '0);
endmodule

bind ppg_group ppg_group_chk #(.PORT_W(PORT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/sim_ppg_group.sv
module sim_ppg_group;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [23:0] pin_in = '0;
    logic [23:0] pin_out;
    logic [23:0] pin_oe;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    ppg_group u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Vector: {rd, addr, data, pins, exp_out, exp_oe, exp_rd}
    localparam int NV = 17;
    localparam logic [90:0] VEC [NV] = '{
        {1'b0, 2'd3, 8'h80, 24'h0, 24'h000000, 24'hFFFFFF, 8'h00}, // R2 all out
        {1'b0, 2'd0, 8'hA5, 24'h0, 24'h0000A5, 24'hFFFFFF, 8'h00}, // R4 A
        {1'b0, 2'd1, 8'h3C, 24'h0, 24'h003CA5, 24'hFFFFFF, 8'h00}, // R4 B
        {1'b0, 2'd2, 8'h7E, 24'h0, 24'h7E3CA5, 24'hFFFFFF, 8'h00}, // R4 C
        {1'b0, 2'd3, 8'h08, 24'h0, 24'h7E3CA5, 24'hFFFFFF, 8'h00}, // R8 ignored
        {1'b0, 2'd3, 8'h88, 24'h0, 24'h000000, 24'h0FFFFF, 8'h00}, // R3 C hi in, R7
        {1'b0, 2'd3, 8'h81, 24'h0, 24'h000000, 24'hF0FFFF, 8'h00}, // R3 C lo in
        {1'b0, 2'd3, 8'h90, 24'h0, 24'h000000, 24'hFFFF00, 8'h00}, // R2 A in
        {1'b0, 2'd1, 8'hC3, 24'h0, 24'h00C300, 24'hFFFF00, 8'h00}, // R5 load keeps oe
        {1'b0, 2'd3, 8'h82, 24'h0, 24'h000000, 24'hFF00FF, 8'h00}, // R2 B in, R7
        {1'b0, 2'd3, 8'h9B, 24'h0, 24'h000000, 24'h000000, 8'h00}, // R2 all in
        {1'b0, 2'd2, 8'h5A, 24'h0, 24'h5A0000, 24'h000000, 8'h00}, // R5 load while input
        {1'b1, 2'd0, 8'h00, 24'h123456, 24'h0, 24'h0, 8'h56},     // R6 A
        {1'b1, 2'd1, 8'h00, 24'h123456, 24'h0, 24'h0, 8'h34},     // R6 B
        {1'b1, 2'd2, 8'h00, 24'h123456, 24'h0, 24'h0, 8'h12},     // R6 C
        {1'b1, 2'd3, 8'h00, 24'h123456, 24'h0, 24'h0, 8'h00},     // R9 ctrl read
        {1'b0, 2'd3, 8'h80, 24'h0, 24'h000000, 24'hFFFFFF, 8'h00}  // R7 clears 5A
    };

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        check("R1 reset oe", pin_oe, 24'h0);
        check("R1 reset out", pin_out, 24'h0);
        check("R9 idle rdata", {16'h0, bus_rdata}, 24'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [90:0] v;
            v = VEC[i];
            if (v[90]) begin
                @(negedge clk);
                pin_in = v[79:56];
                repeat (2) @(negedge clk);
                bus_read(v[89:88], rv);
                check($sformatf("R6/R9 vec%0d rdata", i), {16'h0, rv}, {16'h0, v[7:0]});
            end else begin
                bus_write(v[89:88], v[87:80]);
                check($sformatf("R2-R8 vec%0d out", i), pin_out, v[55:32]);
                check($sformatf("R2/R3 vec%0d oe", i), pin_oe, v[31:8]);
            end
        end

        // R6: exact two-stage latency on port A
        @(negedge clk);
        pin_in = 24'h0000C7;
        bus_addr = 2'd0; bus_rd = 1'b1;
        @(negedge clk);
        #1 check("R6 one edge still old", {16'h0, bus_rdata}, 24'h000056);
        @(negedge clk);
        #1 check("R6 two edges new", {16'h0, bus_rdata}, 24'h0000C7);
        bus_rd = 1'b0;
        #1 check("R9 rd low gives zero", {16'h0, bus_rdata}, 24'h0);

        // R8: flagless control write after loading all latches
        bus_write(2'd0, 8'h11);
        bus_write(2'd2, 8'hEE);
        bus_write(2'd3, 8'h7F);
        check("R8 out kept", pin_out, 24'hEE0011);
        check("R8 oe kept", pin_oe, 24'hFFFFFF);

        // R1: mid-run reset returns to safe state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 midrun oe", pin_oe, 24'h0);
        check("R1 midrun out", pin_out, 24'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release oe", pin_oe, 24'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule